// File: doc/BRIEF.md
# Fractional Microsecond Timebase

This block turns a fast reference clock into a microsecond count. It uses a rational prescaler whose numerator and denominator are each programmed in a one-byte field. It emits H+1 microsecond ticks for every L+1 reference clocks. The prescaler is an accumulator, not an integer divider, so a ratio such as 64 clocks per 5 ticks gives an exact 1 MHz average with no long-term drift. Each tick advances a free-running up counter that software reads.

Software programs the ratio once for the reference frequency. Some examples: 0x000B for 12 MHz, 0x043F for 12.8 MHz, 0x045F for 19.2 MHz and 0x04BF for 38.4 MHz. The ratio can be written again at any time, for instance after a resume, and the count is kept. A hold bit stops both the prescaler and the counter. Clearing the bit lets them continue from where they stopped.

Top module: `usec_timebase`

## Requirements
- R1: After reset the count reads 0, the ratio register reads 0x0000 and the hold bit reads 0. With that default ratio the count advances by one on every reference clock.
- R2: The ratio word has L in bits 7:0 and H in bits 15:8. Both fields are n+1 encoded. When H is less than L, the count advances by exactly (H+1)·k in the (L+1)·k clocks that follow a ratio write.
- R3: When H is greater than or equal to L, the count advances by exactly one on every clock that is not held.
- R4: The count changes by 0 or +1 per clock and wraps modulo 2^COUNT_W.
- R5: A ratio write leaves the count value unchanged. Counting continues from that value at the new rate.
- R6: A ratio write clears the prescaler remainder. With H=0, the first tick after the write comes exactly L+1 clocks later.
- R7: While the hold bit is 1, the count and the prescaler remainder stay constant. After the bit is cleared, counting resumes with the remainder it had, so the clocks before and after the hold add up.
- R8: The register map is: count at 0x00 (read-only, so writes to it have no effect), ratio at 0x04 in bits 15:0 (reads back), and hold at 0x08 in bit 0. Writes take effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` (combinational) |

## Verification
The hardest state to reach from the ports is a remainder partly used up inside the accumulator. That state matters in two cases: a ratio write lands on it, or a hold is set and later cleared on it. The stimulus counts clocks from a ratio write so that the remainder is known exactly. It then stops one clock short of a tick, rewrites the ratio or toggles hold, and checks that the next tick comes at exactly the clock the requirements predict. A second instance with an 8-bit count reaches the wrap within a few hundred clocks.

// File: rtl/usec_timebase_pkg.sv
package usec_timebase_pkg;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int FRAC_W     = 8;
    localparam int RATIO_W    = 2 * FRAC_W;

    localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_RATIO = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_HOLD  = 8'h08;

    typedef struct packed {
        logic [FRAC_W-1:0] num_m1;   // ticks per window minus one (upper byte)
        logic [FRAC_W-1:0] den_m1;   // clocks per window minus one (lower byte)
    } ratio_t;
endpackage

// File: rtl/usec_timebase_regs.sv
module usec_timebase_regs
    import usec_timebase_pkg::*;
#(
    parameter int COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [COUNT_W-1:0] count,
    output ratio_t             ratio,
    output logic               hold,
    output logic               ratio_wr,
    output logic [DATA_W-1:0]  rdata
);
    typedef struct packed {
        ratio_t ratio;
        logic   hold;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d   = regs_q;
        ratio_wr = 1'b0;
        if (wr_en) begin
            if (addr == OFS_RATIO) begin
                regs_d.ratio = ratio_t'(wdata[RATIO_W-1:0]);
                ratio_wr     = 1'b1;
            end
            if (addr == OFS_HOLD) begin
                regs_d.hold = wdata[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_COUNT: rdata = DATA_W'(count);
            OFS_RATIO: rdata = DATA_W'(regs_q.ratio);
            OFS_HOLD:  rdata = DATA_W'(regs_q.hold);
            default:   rdata = '0;
        endcase
    end

    assign ratio = regs_q.ratio;
    assign hold  = regs_q.hold;
endmodule

// File: rtl/usec_timebase_frac.sv
module usec_timebase_frac
    import usec_timebase_pkg::*;
#(
    localparam int ACC_W = FRAC_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ratio_t           ratio,
    input  logic             run,
    input  logic             clear,
    output logic             tick,
    output logic [ACC_W-1:0] rem
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } frac_t;

    frac_t frac_d, frac_q;
    logic [ACC_W-1:0] num, den, sum;

    always_comb begin
        num    = ACC_W'(ratio.num_m1) + ACC_W'(1);
        den    = ACC_W'(ratio.den_m1) + ACC_W'(1);
        sum    = frac_q.acc + num;
        frac_d = frac_q;
        tick   = 1'b0;
        if (clear) begin
            frac_d.acc = '0;
        end else if (run) begin
            if (num >= den) begin
                tick       = 1'b1;
                frac_d.acc = '0;
            end else if (sum >= den) begin
                tick       = 1'b1;
                frac_d.acc = sum - den;
            end else begin
                frac_d.acc = sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frac_q <= '0;
        else        frac_q <= frac_d;
    end

    assign rem = frac_q.acc;
endmodule

// File: rtl/usec_timebase_count.sv
module usec_timebase_count #(
    parameter int COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    output logic [COUNT_W-1:0] count
);
    typedef struct packed {
        logic [COUNT_W-1:0] value;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (tick) cnt_d.value = cnt_q.value + COUNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q.value;
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
    import usec_timebase_pkg::*;
#(
    parameter int COUNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int ACC_W = FRAC_W + 2;

    ratio_t             ratio_w;
    logic               hold_w;
    logic               ratio_wr_w;
    logic               tick_w;
    logic [ACC_W-1:0]   rem_w;
    logic [COUNT_W-1:0] count_w;

    usec_timebase_regs #(.COUNT_W(COUNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .count    (count_w),
        .ratio    (ratio_w),
        .hold     (hold_w),
        .ratio_wr (ratio_wr_w),
        .rdata    (rdata)
    );

    usec_timebase_frac u_frac (
        .clk   (clk),
        .rst_n (rst_n),
        .ratio (ratio_w),
        .run   (!hold_w),
        .clear (ratio_wr_w),
        .tick  (tick_w),
        .rem   (rem_w)
    );

    usec_timebase_count #(.COUNT_W(COUNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_w),
        .count (count_w)
    );
endmodule

// File: rtl/usec_timebase_chk.sv
module usec_timebase_chk
    import usec_timebase_pkg::*;
#(
    parameter int COUNT_W = 32,
    parameter int ACC_W   = FRAC_W + 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               hold,
    input logic               ratio_wr,
    input logic               tick,
    input ratio_t             ratio,
    input logic [ACC_W-1:0]   rem,
    input logic [COUNT_W-1:0] count
);
    // R4: single-step advance with modular wrap
    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count == $past(count)) || (count == $past(count) + COUNT_W'(1)));

    // R7: held count does not move
    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(count) && $stable(rem));

    // R7: no tick while held
    assert_tick_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> !hold);

    // R2: remainder stays below the clock window
    assert_rem_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rem <= ACC_W'(ratio.den_m1));

    // R6: ratio write empties the remainder
    assert_wr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_wr |=> (rem == '0));

    // R5: ratio write leaves the count value as it was
    assert_cfg_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_wr |=> $stable(count));
endmodule

bind usec_timebase usec_timebase_chk #(.COUNT_W(COUNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (hold_w),
    .ratio_wr (ratio_wr_w),
    .tick     (tick_w),
    .ratio    (ratio_w),
    .rem      (rem_w),
    .count    (count_w)
);

// File: tb/usec_timebase_bench.sv
module usec_timebase_bench;
    import usec_timebase_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata, rdata_n;

    int applied = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    usec_timebase u_usec_timebase (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    usec_timebase #(.COUNT_W(8)) u_usec_timebase_narrow (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata_n)
    );

    // ratio word, clocks to wait, expected count advance
    localparam int NV = 8;
    localparam logic [15:0] V_RATIO [NV] = '{16'h000B, 16'h043F, 16'h045F, 16'h04BF,
                                             16'h0019, 16'h0000, 16'h0507, 16'h0301};
    localparam int V_CLKS [NV] = '{36, 128, 192, 192, 52, 1, 24, 10};
    localparam int V_ADV  [NV] = '{3, 10, 10, 5, 2, 1, 18, 10};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", applied, misses);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] c0, c1, v;
        // R1: reset values
        @(negedge clk);
        rd(OFS_COUNT, v); check("R1 count", v, 0);
        rd(OFS_RATIO, v); check("R1 ratio", v, 0);
        rd(OFS_HOLD, v);  check("R1 hold", v, 0);
        rst_n = 1'b1;
        wait_clks(5);
        rd(OFS_COUNT, v); check("R1 default rate", v, 5);
        // R4: narrow instance wraps modulo 2^8
        wait_clks(256);
        addr = OFS_COUNT; #1;
        check("R4 wrap", rdata_n, 5);

        // R2/R3: ratio table
        for (int i = 0; i < NV; i++) begin
            wr(OFS_RATIO, 32'(V_RATIO[i]));
            rd(OFS_RATIO, v); check("R8 ratio readback", v, 32'(V_RATIO[i]));
            rd(OFS_COUNT, c0);
            wait_clks(V_CLKS[i]);
            rd(OFS_COUNT, c1);
            check(V_RATIO[i][15:8] >= V_RATIO[i][7:0] ? "R3 advance" : "R2 advance",
                  c1 - c0, 32'(V_ADV[i]));
        end

        // R5: ratio write keeps the count
        wr(OFS_RATIO, 32'h0000);
        rd(OFS_COUNT, c0);
        wr(OFS_RATIO, 32'h000B);
        rd(OFS_COUNT, c1); check("R5 keep", c1, c0);

        // R6: remainder cleared by rewrite, 11 clocks in
        wait_clks(11);
        rd(OFS_COUNT, c1); check("R6 pre", c1 - c0, 0);
        wr(OFS_RATIO, 32'h000B);
        wait_clks(11);
        rd(OFS_COUNT, c1); check("R6 no early tick", c1 - c0, 0);
        wait_clks(1);
        rd(OFS_COUNT, c1); check("R6 tick at L+1", c1 - c0, 1);

        // R7: hold keeps count and remainder
        wr(OFS_RATIO, 32'h000B);
        rd(OFS_COUNT, c0);
        wait_clks(6);
        wr(OFS_HOLD, 32'h1);             // this edge still runs: 7 run clocks
        rd(OFS_HOLD, v); check("R8 hold readback", v, 1);
        rd(OFS_COUNT, c1);
        wait_clks(30);
        rd(OFS_COUNT, v); check("R7 held", v, c1);
        wr(OFS_HOLD, 32'h0);             // edge with hold still set: no run
        wait_clks(4);
        rd(OFS_COUNT, v); check("R7 resume remainder", v - c0, 0);
        wait_clks(1);
        rd(OFS_COUNT, v); check("R7 resume tick", v - c0, 1);

        // R8: count register ignores writes
        wr(OFS_RATIO, 32'h0000);
        rd(OFS_COUNT, c0);
        wr(OFS_COUNT, 32'hFFFF_FFFF);
        rd(OFS_COUNT, v); check("R8 count read-only", v, c0 + 1);

        done = 1'b1;
        finish_run();
    end
endmodule